// File: doc/BRIEF.md
# Knot-Based Gamma Curve Mapper

This block turns an 8-bit pixel code on each of three colour channels (red, green, blue) into a 10-bit drive level for a display source driver. Each channel's transfer curve is described by 26 knots. The knots sit at fixed input codes that are spaced closely near black and near white and widely in the mid-tones. Between two knots the output is found by straight-line interpolation. Six curves are stored: one per colour for positive drive polarity and one per colour for negative drive polarity. A per-pixel polarity input chooses which set of three is used.

Curves are written through a byte-wide load port. A burst names one curve and carries its 26 knots as byte pairs. The new curve replaces the stored one only when the whole burst has arrived, so a broken burst never leaves a half-written curve in use. Whenever a curve is committed, the block checks that its knots rise strictly and reports the result on one status bit per curve.

Top module: `gamma_knot_mapper`

## Requirements
- R1: A pixel presented with `px_valid` high is sampled at a rising edge. Its three levels and `out_valid` appear after the second rising edge that follows, so the latency is two cycles. A new pixel can be accepted on every cycle.
- R2: The knot input codes are, in order of knot index 0..25: 0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128, 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254 and 255. An input equal to a knot code returns that knot's stored level exactly.
- R3: For an input x with knot codes x_lo < x < x_hi and rising levels v_lo < v_hi, the output is v_lo + floor((v_hi - v_lo) * (x - x_lo) / (x_hi - x_lo)).
- R4: A load burst starts with a byte that has `ld_valid` and `ld_first` both high. That byte also carries the curve code on `ld_curve`. The burst is 52 bytes long and gives the knots in index order, two bytes per knot. In the first byte of a pair, bits 1:0 are level bits 9:8 and bits 7:2 are ignored. The second byte of a pair is level bits 7:0. The curve is replaced after the 52nd byte, and pixels sampled two or more cycles after that byte use the new curve.
- R5: `curve_ok[c]` is high after reset. At every commit of curve c it is rewritten: high if each knot is strictly greater than the one before it, and low otherwise.
- R6: An unfinished burst leaves the stored curve and its `curve_ok` bit unchanged. A burst is unfinished if a new `ld_first` byte arrives first or if bytes simply stop. Bytes with `ld_first` low and no burst open are ignored. A burst that names curve code 6 or 7 is ignored in full.
- R7: Curve codes are 0 = red positive, 1 = green positive, 2 = blue positive, 3 = red negative, 4 = green negative and 5 = blue negative. When `px_neg` is 0 a pixel uses codes 0 to 2, and when it is 1 it uses codes 3 to 5.
- R8: After reset, every curve has level 1 + floor(x * 1021 / 255) at each knot code x. This gives 0x001 at code 0 and 0x3FE at code 255.
- R9: If a segment's upper knot is not above its lower knot, every input in that segment returns the lower knot's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load byte present |
| ld_first | input | 1 | This byte opens a new burst |
| ld_curve | input | 3 | Target curve code, sampled with the first byte |
| ld_data | input | 8 | Load byte |
| px_valid | input | 1 | Pixel present |
| px_neg | input | 1 | Polarity: 0 positive curves, 1 negative curves |
| px_red | input | 8 | Red input code |
| px_green | input | 8 | Green input code |
| px_blue | input | 8 | Blue input code |
| out_valid | output | 1 | Output levels valid |
| out_red | output | 10 | Red drive level |
| out_green | output | 10 | Green drive level |
| out_blue | output | 10 | Blue drive level |
| curve_ok | output | 6 | Per-curve strictly-rising flag, bit index = curve code |

## Verification
On every cycle the assertions check the following. The valid bit moves through both pipeline stages without being lost or invented. A lane that sits exactly on a knot emits that knot. A rising segment keeps its output between its two knots, and a flat or falling segment emits its lower knot. A commit happens only right after a byte of an open burst, and never for codes above 5. The status bit changes only at a commit, and then to the value the loader measured. Other behaviour can only be shown by the bench's scenarios: the exact truncated interpolation values, the byte order and the ignored upper bits of a pair, polarity routing, discarding an interrupted or misdirected burst, and the reset curve.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int PIX_W      = 8;
  localparam int LVL_W      = 10;
  localparam int KNOTS      = 26;
  localparam int SEGS       = KNOTS - 1;
  localparam int CHANS      = 3;
  localparam int POLS       = 2;
  localparam int CURVES     = CHANS * POLS;
  localparam int KIDX_W     = $clog2(KNOTS);
  localparam int CID_W      = $clog2(CURVES);
  localparam int BYTE_W     = 8;
  localparam int HI_W       = LVL_W - BYTE_W;
  localparam int CURVE_BYTES = 2 * KNOTS;
  localparam int BCNT_W     = $clog2(CURVE_BYTES + 1);
  localparam int SH_W       = $clog2(PIX_W);
  localparam int PIX_MAX    = (1 << PIX_W) - 1;
  localparam int LVL_MAX    = (1 << LVL_W) - 1;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [LVL_W-1:0]  level_t;
  typedef logic [KIDX_W-1:0] kidx_t;
  typedef logic [CID_W-1:0]  cid_t;
  typedef logic [SH_W-1:0]   shift_t;

  // Fixed input code of each knot; the spacing between neighbours is always a power of two.
  function automatic pix_t knot_pos(input int k);
    case (k)
      0:  return 8'd0;
      1:  return 8'd1;
      2:  return 8'd3;
      3:  return 8'd5;
      4:  return 8'd7;
      5:  return 8'd11;
      6:  return 8'd15;
      7:  return 8'd23;
      8:  return 8'd31;
      9:  return 8'd47;
      10: return 8'd63;
      11: return 8'd95;
      12: return 8'd127;
      13: return 8'd128;
      14: return 8'd160;
      15: return 8'd192;
      16: return 8'd208;
      17: return 8'd224;
      18: return 8'd232;
      19: return 8'd240;
      20: return 8'd244;
      21: return 8'd248;
      22: return 8'd250;
      23: return 8'd252;
      24: return 8'd254;
      default: return 8'd255;
    endcase
  endfunction

  // Index of the segment whose lower knot is the last one not above x.
  function automatic kidx_t find_seg(input pix_t x);
    kidx_t r;
    r = '0;
    for (int k = 0; k < SEGS; k++)
      if (knot_pos(k) <= x) r = kidx_t'(k);
    return r;
  endfunction

  // log2 of the width of segment s.
  function automatic shift_t seg_shift(input int s);
    int     w;
    shift_t r;
    w = int'(knot_pos(s + 1)) - int'(knot_pos(s));
    r = '0;
    for (int b = 0; b < PIX_W; b++)
      if (w == (1 << b)) r = shift_t'(b);
    return r;
  endfunction

  // Reset curve: a straight ramp from 1 to LVL_MAX-1 across the input range.
  function automatic level_t default_level(input int k);
    return level_t'(1 + (int'(knot_pos(k)) * (LVL_MAX - 2)) / PIX_MAX);
  endfunction

  // Linear blend inside a power-of-two segment; flat or falling segments hold the lower knot.
  function automatic level_t blend(input level_t lo, input level_t hi,
                                   input pix_t off, input shift_t sh);
    int span;
    int step;
    if (hi <= lo) return lo;
    span = int'(hi) - int'(lo);
    step = (span * int'(off)) >> sh;
    return level_t'(int'(lo) + step);
  endfunction
endpackage

// File: rtl/gamma_loader.sv
module gamma_loader
  import gamma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid_i,
  input  logic                ld_first_i,
  input  cid_t                ld_curve_i,
  input  logic [BYTE_W-1:0]   ld_data_i,
  output logic                commit_o,
  output cid_t                commit_curve_o,
  output logic                commit_ok_o,
  output level_t              stage_o [KNOTS]
);
  logic                active_q;
  logic [BCNT_W-1:0]   cnt_q;
  cid_t                sel_q;
  logic [HI_W-1:0]     hi_q;
  level_t              prev_q;
  logic                mono_q;
  logic                commit_q;
  logic                commit_ok_q;
  level_t              stage_q [KNOTS];

  // Named events of the byte assembler.
  logic   start_w;
  logic   take_w;
  logic   low_byte_w;
  logic   last_w;
  logic   drop_w;
  kidx_t  kidx_w;
  level_t knot_w;

  assign start_w    = ld_valid_i && ld_first_i;
  assign take_w     = ld_valid_i && !ld_first_i && active_q;
  assign low_byte_w = cnt_q[0];
  assign kidx_w     = kidx_t'(cnt_q >> 1);
  assign knot_w     = {hi_q, ld_data_i};
  assign drop_w     = (kidx_w != '0) && (knot_w <= prev_q);
  assign last_w     = take_w && low_byte_w && (cnt_q == BCNT_W'(CURVE_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      sel_q       <= '0;
      hi_q        <= '0;
      prev_q      <= '0;
      mono_q      <= 1'b1;
      commit_q    <= 1'b0;
      commit_ok_q <= 1'b1;
      for (int k = 0; k < KNOTS; k++) stage_q[k] <= '0;
    end else begin
      commit_q <= 1'b0;
      if (start_w) begin
        active_q <= (int'(ld_curve_i) < CURVES);
        cnt_q    <= BCNT_W'(1);
        sel_q    <= ld_curve_i;
        hi_q     <= ld_data_i[HI_W-1:0];
        mono_q   <= 1'b1;
      end else if (take_w) begin
        if (!low_byte_w) begin
          hi_q  <= ld_data_i[HI_W-1:0];
          cnt_q <= cnt_q + 1'b1;
        end else begin
          stage_q[kidx_w] <= knot_w;
          prev_q          <= knot_w;
          if (drop_w) mono_q <= 1'b0;
          if (last_w) begin
            active_q    <= 1'b0;
            commit_q    <= 1'b1;
            commit_ok_q <= mono_q && !drop_w;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign commit_o       = commit_q;
  assign commit_curve_o = sel_q;
  assign commit_ok_o    = commit_ok_q;
  assign stage_o        = stage_q;

  // R4: a commit is always the cycle right after a continuation byte.
  p_commit_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(ld_valid_i && !ld_first_i));
  // R4: a burst commits once and then closes.
  p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  // R6: reserved curve codes never reach the bank.
  p_commit_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (int'(sel_q) < CURVES));
endmodule

// File: rtl/gamma_curve_bank.sv
module gamma_curve_bank
  import gamma_pkg::*;
#(
  parameter int LANES = CHANS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit_i,
  input  cid_t   commit_curve_i,
  input  logic   commit_ok_i,
  input  level_t stage_i [KNOTS],
  input  cid_t   rd_curve_i [LANES],
  input  kidx_t  rd_seg_i [LANES],
  output level_t rd_lo_o [LANES],
  output level_t rd_hi_o [LANES],
  output logic [CURVES-1:0] curve_ok_o
);
  level_t            mem_q [CURVES][KNOTS];
  logic [CURVES-1:0] ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q <= '1;
      for (int c = 0; c < CURVES; c++)
        for (int k = 0; k < KNOTS; k++)
          mem_q[c][k] <= default_level(k);
    end else if (commit_i) begin
      ok_q[commit_curve_i] <= commit_ok_i;
      for (int k = 0; k < KNOTS; k++)
        mem_q[commit_curve_i][k] <= stage_i[k];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_lo_o[l] = mem_q[rd_curve_i[l]][rd_seg_i[l]];
    assign rd_hi_o[l] = mem_q[rd_curve_i[l]][kidx_t'(rd_seg_i[l] + 1'b1)];
  end

  assign curve_ok_o = ok_q;

  // R5: a commit writes the flag measured by the loader.
  p_ok_follows_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (ok_q[$past(commit_curve_i)] == $past(commit_ok_i)));
  // R6: without a commit the flags do not move.
  p_ok_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(ok_q));
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
  import gamma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pix_t   pix_i,
  output kidx_t  seg_o,
  input  level_t lo_i,
  input  level_t hi_i,
  output level_t level_o
);
  kidx_t  seg_w;
  pix_t   off_q;
  shift_t sh_q;
  level_t lo_q;
  level_t hi_q;
  level_t level_q;

  assign seg_w = find_seg(pix_i);
  assign seg_o = seg_w;

  // Stage 1: segment lookup and knot fetch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
      sh_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      off_q <= pix_i - knot_pos(int'(seg_w));
      sh_q  <= seg_shift(int'(seg_w));
      lo_q  <= lo_i;
      hi_q  <= hi_i;
    end
  end

  // Stage 2: interpolation.
  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= blend(lo_q, hi_q, off_q, sh_q);
  end

  assign level_o = level_q;

  // R2: sitting on a knot yields that knot.
  p_knot_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q == '0) |=> (level_q == $past(lo_q)));
  // R3: a rising segment stays between its knots.
  p_inside_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q > lo_q) |=> ((level_q >= $past(lo_q)) && (level_q <= $past(hi_q))));
  // R9: a flat or falling segment holds its lower knot.
  p_flat_segment_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q <= lo_q) |=> (level_q == $past(lo_q)));
endmodule

// File: rtl/gamma_knot_mapper.sv
module gamma_knot_mapper
  import gamma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic                 ld_first,
  input  logic [CID_W-1:0]     ld_curve,
  input  logic [BYTE_W-1:0]    ld_data,
  input  logic                 px_valid,
  input  logic                 px_neg,
  input  logic [PIX_W-1:0]     px_red,
  input  logic [PIX_W-1:0]     px_green,
  input  logic [PIX_W-1:0]     px_blue,
  output logic                 out_valid,
  output logic [LVL_W-1:0]     out_red,
  output logic [LVL_W-1:0]     out_green,
  output logic [LVL_W-1:0]     out_blue,
  output logic [CURVES-1:0]    curve_ok
);
  logic   commit_w;
  cid_t   commit_curve_w;
  logic   commit_ok_w;
  level_t stage_w [KNOTS];

  pix_t   lane_px    [CHANS];
  cid_t   lane_curve [CHANS];
  kidx_t  lane_seg   [CHANS];
  level_t lane_lo    [CHANS];
  level_t lane_hi    [CHANS];
  level_t lane_lvl   [CHANS];

  logic   v1_q;
  logic   v2_q;

  gamma_loader u_loader (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_valid_i     (ld_valid),
    .ld_first_i     (ld_first),
    .ld_curve_i     (ld_curve),
    .ld_data_i      (ld_data),
    .commit_o       (commit_w),
    .commit_curve_o (commit_curve_w),
    .commit_ok_o    (commit_ok_w),
    .stage_o        (stage_w)
  );

  gamma_curve_bank #(.LANES(CHANS)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_i       (commit_w),
    .commit_curve_i (commit_curve_w),
    .commit_ok_i    (commit_ok_w),
    .stage_i        (stage_w),
    .rd_curve_i     (lane_curve),
    .rd_seg_i       (lane_seg),
    .rd_lo_o        (lane_lo),
    .rd_hi_o        (lane_hi),
    .curve_ok_o     (curve_ok)
  );

  assign lane_px[0] = px_red;
  assign lane_px[1] = px_green;
  assign lane_px[2] = px_blue;

  for (genvar c = 0; c < CHANS; c++) begin : g_lane
    assign lane_curve[c] = px_neg ? cid_t'(c + CHANS) : cid_t'(c);
    gamma_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .pix_i   (lane_px[c]),
      .seg_o   (lane_seg[c]),
      .lo_i    (lane_lo[c]),
      .hi_i    (lane_hi[c]),
      .level_o (lane_lvl[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= px_valid;
      v2_q <= v1_q;
    end
  end

  assign out_valid = v2_q;
  assign out_red   = lane_lvl[0];
  assign out_green = lane_lvl[1];
  assign out_blue  = lane_lvl[2];

  // R1: the valid bit walks through both stages one cycle at a time.
  p_stage1_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q == $past(px_valid));
  p_stage2_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(v1_q));
endmodule

// File: tb/gamma_knot_mapper_test.sv
module gamma_knot_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0, ld_first = 1'b0;
  logic [2:0] ld_curve = '0;
  logic [7:0] ld_data = '0;
  logic       px_valid = 1'b0, px_neg = 1'b0;
  logic [7:0] px_red = '0, px_green = '0, px_blue = '0;
  logic       out_valid;
  logic [9:0] out_red, out_green, out_blue;
  logic [5:0] curve_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_knot_mapper uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_first(ld_first),
    .ld_curve(ld_curve), .ld_data(ld_data), .px_valid(px_valid), .px_neg(px_neg),
    .px_red(px_red), .px_green(px_green), .px_blue(px_blue), .out_valid(out_valid),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue), .curve_ok(curve_ok)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int xs[26] = '{0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128,
                 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255};
  int mdl[6][26];
  int ok_mdl;

  typedef struct {
    int    r, g, b;
    int    due;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int want(input int c, input int x);
    int k, lo, hi;
    k = 0;
    for (int i = 0; i < 25; i++) if (xs[i] <= x) k = i;
    lo = mdl[c][k];
    hi = mdl[c][k+1];
    if (hi <= lo) return lo;
    return lo + ((hi - lo) * (x - xs[k])) / (xs[k+1] - xs[k]);
  endfunction

  function automatic bit on_knot(input int x);
    for (int i = 0; i < 26; i++) if (xs[i] == x) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit rising(input int lv[26]);
    for (int i = 1; i < 26; i++) if (lv[i] <= lv[i-1]) return 1'b0;
    return 1'b1;
  endfunction

  // Monitor: pops the scoreboard whenever the design produces a pixel.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1: actual unexpected output expected none");
      end else begin
        e = q.pop_front();
        check({"R1 latency ", e.tag}, cyc, e.due);
        check({"red ", e.tag}, int'(out_red), e.r);
        check({"green ", e.tag}, int'(out_green), e.g);
        check({"blue ", e.tag}, int'(out_blue), e.b);
      end
    end
  end

  task automatic send_px(input int neg, input int r, input int g, input int b, input string base);
    exp_t e;
    @(negedge clk);
    px_valid = 1'b1;
    px_neg   = neg[0];
    px_red   = 8'(r);
    px_green = 8'(g);
    px_blue  = 8'(b);
    e.r   = want(3*neg + 0, r);
    e.g   = want(3*neg + 1, g);
    e.b   = want(3*neg + 2, b);
    e.due = cyc + 2;
    e.tag = $sformatf("%s %s x=%0d neg=%0d", base, on_knot(r) ? "R2" : "R3", r, neg);
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      px_valid = 1'b0;
    end
  endtask

  task automatic sweep(input int neg, input string base);
    for (int x = 0; x < 256; x++) send_px(neg, x, (x + 85) & 255, (x + 170) & 255, base);
    idle(4);
  endtask

  task automatic load(input int code, input int lv[26], input int nbytes, input int junk);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_first = (i == 0);
      ld_curve = 3'(code);
      if (i % 2 == 0) ld_data = 8'(((junk & 63) << 2) | ((lv[i/2] >> 8) & 3));
      else            ld_data = 8'(lv[i/2] & 255);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    ld_first = 1'b0;
    if (nbytes == 52 && code < 6) begin
      for (int k = 0; k < 26; k++) mdl[code][k] = lv[k];
      if (rising(lv)) ok_mdl = ok_mdl | (1 << code);
      else            ok_mdl = ok_mdl & ~(1 << code);
    end
    idle(3);
  endtask

  int lv_a[26], lv_b[26], lv_c[26], lv_d[26];

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < 26; k++) mdl[c][k] = 1 + (xs[k] * 1021) / 255;
    ok_mdl = 63;
    for (int k = 0; k < 26; k++) begin
      lv_a[k] = 10 + 39 * k;
      lv_b[k] = 1000 - 30 * k;
      lv_c[k] = 5 + 40 * k - (k % 3);
      lv_d[k] = 3 + 20 * k;
    end
    lv_d[15] = lv_d[14];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R5 reset curve_ok", int'(curve_ok), 63);

    // R6: bytes with no burst open change nothing.
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_first = 1'b0;
      ld_data  = 8'(i * 17);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    idle(3);
    sweep(0, "R8 R6 default pos");
    sweep(1, "R8 default neg");

    // R4/R5: full rising load into red positive.
    load(0, lv_a, 52, 0);
    check("R5 rising curve 0", int'(curve_ok), ok_mdl);
    sweep(0, "R4 R7 red pos loaded");
    sweep(1, "R7 neg untouched");

    // R4 upper bits ignored, R5 falling flagged, R9 flat output.
    load(4, lv_b, 52, 43);
    check("R5 falling curve 4", int'(curve_ok), ok_mdl);
    sweep(1, "R9 R4 falling green neg");

    // R6: interrupted burst on curve 0, then full burst on curve 1.
    load(0, lv_c, 20, 0);
    load(1, lv_c, 52, 0);
    check("R6 after interrupt", int'(curve_ok), ok_mdl);
    sweep(0, "R6 interrupted red pos");

    // R6: burst that stops, then a burst to reserved code 6.
    load(2, lv_c, 30, 0);
    sweep(0, "R6 stopped blue pos");
    load(6, lv_b, 52, 0);
    check("R6 reserved code", int'(curve_ok), ok_mdl);
    sweep(0, "R6 reserved code pos");
    sweep(1, "R6 reserved code neg");

    // R5/R9: equal neighbours on blue negative.
    load(5, lv_d, 52, 0);
    check("R5 equal knots curve 5", int'(curve_ok), ok_mdl);
    sweep(1, "R9 equal knots blue neg");

    // R5: reloading a rising curve restores the flag.
    load(4, lv_c, 52, 0);
    check("R5 restored curve 4", int'(curve_ok), ok_mdl);
    sweep(1, "R3 reloaded green neg");

    idle(4);
    check("R1 scoreboard drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule